// File: doc/BRIEF.md
# External Bus Access Timing Generator

This block runs one access at a time on an external SRAM-style bus. A host raises a request with an address, a direction, write data and byte enables. The block then asserts chip select and the address together with either the read strobe or the write strobe plus byte strobes. It keeps the strobe asserted for one base bus cycle plus a programmed number of wait cycles. A wait input from the device can stretch the strobe further. The block then releases the strobe, keeps address and chip select for a programmed hold time, and signals completion with a single-cycle pulse.

The internal clock runs at twice the bus-cycle rate. One bus cycle is two clock periods (two half-cycles), so the hold time can be set in half-cycle steps.

A small configuration register sets the timing. It holds a 4-bit wait code with a non-linear table, a bit that masks the device wait input, and a 2-bit hold code. The configuration is snapshotted when a request is accepted, so a write during an access applies from the next access on.

Top module: `ebt_bus_timer`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x00A (wait code 10, wait input not masked, hold code 0) and `cfg_err` is 0. `bus_cs_n`, `bus_rd_n` and `bus_we_n` are 1, `bus_be_n` is all ones and `done` is 0.
- R2: Configuration layout is wait code in bits [3:0], mask in bit 8 and hold code in bits [10:9]. The wait code selects W wait bus cycles: codes 0 to 6 give 0 to 6, 7 gives 8, 8 gives 10, 9 gives 12, 10 gives 14, 11 gives 18 and 12 gives 24. With no stretch, the strobe is low for exactly 2*(1+W) clock periods.
- R3: Wait codes 13, 14 and 15 behave as W=24. Writing any of them sets `cfg_err`, which stays set until reset.
- R4: With mask = 0, `bus_wait` (active high) is sampled in the last clock period of the strobe and in the last period of each extension. Each high sample adds 2 clock periods to the strobe. This also applies when W = 0.
- R5: With mask = 1, `bus_wait` has no effect on the strobe length.
- R6: After the strobe rises, `bus_cs_n` stays low and `bus_addr` stays unchanged for 2*H+1 clock periods, where H is the hold code (0.5 to 3.5 bus cycles).
- R7: For a read, `rd_data` holds the value of `bus_rdata` sampled in the last clock period before `bus_rd_n` rises.
- R8: A read pulls only `bus_rd_n` low. A write pulls only `bus_we_n` low. During a write strobe, `bus_be_n` equals the inverted request byte enables and `bus_wdata` equals the request data. At all other times `bus_be_n` is all ones.
- R9: `done` is high for one clock period, in the period after `bus_cs_n` rises. A request that arrives while an access is in progress is ignored.
- R10: Configuration bits [7:4] always read 0, and writing them has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus-cycle rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 11 | Configuration write value |
| cfg_rdata | output | 11 | Configuration readback |
| cfg_err | output | 1 | Sticky flag set when a reserved wait code is written |
| req | input | 1 | Access request, taken only while idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables, active high |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Captured read data |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_addr | output | ADDR_W | Bus address |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_be_n | output | DATA_W/8 | Byte strobes, active low |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Bus read data |
| bus_wait | input | 1 | Device wait request, active high |

## Verification
The hardest case to reach from the ports is the wait input landing exactly on the sampling point of each extension. This matters most at wait code 0, where the first sample falls in the second half-cycle of the strobe. The bench counts the strobe half-cycles as they happen. It holds `bus_wait` high for exactly as many half-cycles as are needed for a chosen number of extensions, so each sample point sees a known level. It also changes `bus_rdata` on every half-cycle, so a capture one period early or late gives a different value. The sweep covers every wait code, every hold code, both mask values and both directions.

// File: rtl/ebt_pkg.sv
package ebt_pkg;

  localparam int CFG_W        = 11;
  localparam int CFG_WAIT_LSB = 0;
  localparam int CFG_MASK_BIT = 8;
  localparam int CFG_HOLD_LSB = 9;
  localparam int MAX_WAIT     = 24;
  localparam int WAIT_W       = $clog2(MAX_WAIT + 1);
  localparam logic [3:0] WAIT_RESET   = 4'd10;
  localparam logic [3:0] RSV_FIRST    = 4'd13;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STROBE = 2'd1,
    ST_HOLD   = 2'd2,
    ST_DONE   = 2'd3
  } seq_state_e;

  // Non-linear wait table; reserved codes fall back to the longest setting.
  function automatic logic [WAIT_W-1:0] wait_decode(input logic [3:0] code);
    logic [WAIT_W-1:0] w;
    case (code)
      4'd0, 4'd1, 4'd2, 4'd3,
      4'd4, 4'd5, 4'd6: w = WAIT_W'(code);
      4'd7:             w = WAIT_W'(8);
      4'd8:             w = WAIT_W'(10);
      4'd9:             w = WAIT_W'(12);
      4'd10:            w = WAIT_W'(14);
      4'd11:            w = WAIT_W'(18);
      default:          w = WAIT_W'(MAX_WAIT);
    endcase
    return w;
  endfunction

endpackage

// File: rtl/ebt_cfg.sv
module ebt_cfg
  import ebt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wdata,
  output logic [3:0]       code_q,
  output logic             mask_q,
  output logic [1:0]       hold_q,
  output logic             err_q,
  output logic [CFG_W-1:0] rdata
);

  logic [3:0] code_n;
  logic       mask_n;
  logic [1:0] hold_n;
  logic       err_en;

  always_comb begin
    code_n = wdata[CFG_WAIT_LSB +: 4];
    mask_n = wdata[CFG_MASK_BIT];
    hold_n = wdata[CFG_HOLD_LSB +: 2];
    err_en = wr_en && (code_n >= RSV_FIRST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= WAIT_RESET;
      mask_q <= 1'b0;
      hold_q <= 2'd0;
      err_q  <= 1'b0;
    end else begin
      if (wr_en) begin
        code_q <= code_n;
        mask_q <= mask_n;
        hold_q <= hold_n;
      end
      if (err_en) begin
        err_q <= 1'b1;
      end
    end
  end

  always_comb begin
    rdata                       = '0;
    rdata[CFG_WAIT_LSB +: 4]    = code_q;
    rdata[CFG_MASK_BIT]         = mask_q;
    rdata[CFG_HOLD_LSB +: 2]    = hold_q;
  end

  // R3: the error flag never clears once set
  a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R3: a reserved code write raises the flag on the next cycle
  a_r3_err_on_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[CFG_WAIT_LSB +: 4] >= RSV_FIRST) |=> err_q);

endmodule

// File: rtl/ebt_seq.sv
module ebt_seq
  import ebt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WAIT_W-1:0] wait_cyc,
  input  logic              mask,
  input  logic [1:0]        hold,
  input  logic              ext_wait,
  output logic              idle,
  output logic              strobe_on,
  output logic              cs_on,
  output logic              done,
  output logic              cap
);

  localparam int CW = $clog2(2 * MAX_WAIT + 2);

  seq_state_e   state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic         mask_q;
  logic [1:0]   hold_q;
  logic         snap_en;
  logic         stretch;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    snap_en = 1'b0;
    cap     = 1'b0;
    stretch = ext_wait && !mask_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_n = ST_STROBE;
          cnt_n   = CW'({wait_cyc, 1'b0}) | CW'(1);
          snap_en = 1'b1;
        end
      end
      ST_STROBE: begin
        if (cnt_q != '0) begin
          cnt_n = cnt_q - CW'(1);
        end else if (stretch) begin
          cnt_n = CW'(1);
        end else begin
          cap     = 1'b1;
          state_n = ST_HOLD;
          cnt_n   = CW'({hold_q, 1'b0});
        end
      end
      ST_HOLD: begin
        if (cnt_q != '0) begin
          cnt_n = cnt_q - CW'(1);
        end else begin
          state_n = ST_DONE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      mask_q  <= 1'b0;
      hold_q  <= 2'd0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      if (snap_en) begin
        mask_q <= mask;
        hold_q <= hold;
      end
    end
  end

  assign idle      = (state_q == ST_IDLE);
  assign strobe_on = (state_q == ST_STROBE);
  assign cs_on     = (state_q == ST_STROBE) || (state_q == ST_HOLD);
  assign done      = (state_q == ST_DONE);

  // R7: capture happens only as the strobe ends and the hold begins
  a_r7_cap_ends_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (cs_on && !strobe_on));

  // R9: a start is acted on only from idle
  a_r9_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle) |=> strobe_on);

endmodule

// File: rtl/ebt_bus_timer.sv
module ebt_bus_timer
  import ebt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [CFG_W-1:0]    cfg_wdata,
  output logic [CFG_W-1:0]    cfg_rdata,
  output logic                cfg_err,
  input  logic                req,
  input  logic                req_we,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_be,
  output logic                done,
  output logic [DATA_W-1:0]   rd_data,
  output logic                bus_cs_n,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic                bus_rd_n,
  output logic                bus_we_n,
  output logic [DATA_W/8-1:0] bus_be_n,
  output logic [DATA_W-1:0]   bus_wdata,
  input  logic [DATA_W-1:0]   bus_rdata,
  input  logic                bus_wait
);

  localparam int BE_W = DATA_W / 8;

  // asynchronous assert, synchronous release
  logic rst_s1, rst_s2, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end
  assign rst_i = rst_s2;

  logic [3:0]        code_q;
  logic              mask_q;
  logic [1:0]        hold_q;
  logic [WAIT_W-1:0] wait_cyc;
  logic              idle, strobe_on, cs_on, cap, start;

  ebt_cfg u_cfg (
    .clk    (clk),
    .rst_n  (rst_i),
    .wr_en  (cfg_wr),
    .wdata  (cfg_wdata),
    .code_q (code_q),
    .mask_q (mask_q),
    .hold_q (hold_q),
    .err_q  (cfg_err),
    .rdata  (cfg_rdata)
  );

  assign wait_cyc = wait_decode(code_q);
  assign start    = req && idle;

  ebt_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_i),
    .start     (start),
    .wait_cyc  (wait_cyc),
    .mask      (mask_q),
    .hold      (hold_q),
    .ext_wait  (bus_wait),
    .idle      (idle),
    .strobe_on (strobe_on),
    .cs_on     (cs_on),
    .done      (done),
    .cap       (cap)
  );

  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [BE_W-1:0]   be_q;
  logic [DATA_W-1:0] rd_q;
  logic              rd_cap_en;

  assign rd_cap_en = cap && !we_q;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      rd_q    <= '0;
    end else begin
      if (start) begin
        we_q    <= req_we;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        be_q    <= req_be;
      end
      if (rd_cap_en) begin
        rd_q <= bus_rdata;
      end
    end
  end

  assign bus_cs_n  = !cs_on;
  assign bus_rd_n  = !(strobe_on && !we_q);
  assign bus_we_n  = !(strobe_on && we_q);
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;
  assign rd_data   = rd_q;

  always_comb begin
    if (bus_we_n) bus_be_n = '1;
    else          bus_be_n = ~be_q;
  end

  // R8: never both strobes at once
  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_i)
    !(!bus_rd_n && !bus_we_n));

  // R6: any strobe lies inside chip select
  a_r6_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_i)
    (!bus_rd_n || !bus_we_n) |-> !bus_cs_n);

  // R6: address holds while chip select stays low
  a_r6_addr_stable: assert property (@(posedge clk) disable iff (!rst_i)
    (!bus_cs_n && $past(!bus_cs_n)) |-> $stable(bus_addr));

  // R9: done is a single pulse
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_i)
    done |=> !done);

  // R9: done follows chip select negation
  a_r9_done_after_cs: assert property (@(posedge clk) disable iff (!rst_i)
    done |-> (bus_cs_n && $past(!bus_cs_n)));

endmodule

// File: tb/test_ebt_bus_timer.sv
module test_ebt_bus_timer;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int BW = DW / 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_wr;
  logic [10:0]   cfg_wdata;
  logic [10:0]   cfg_rdata;
  logic          cfg_err;
  logic          req, req_we;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [BW-1:0] req_be;
  logic          done;
  logic [DW-1:0] rd_data;
  logic          bus_cs_n;
  logic [AW-1:0] bus_addr;
  logic          bus_rd_n, bus_we_n;
  logic [BW-1:0] bus_be_n;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;
  logic          bus_wait;

  int n_cmp = 0;
  int n_mis = 0;
  int n_acc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ebt_bus_timer #(.ADDR_W(AW), .DATA_W(DW)) i_ebt_bus_timer (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
    .req(req), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .done(done), .rd_data(rd_data),
    .bus_cs_n(bus_cs_n), .bus_addr(bus_addr), .bus_rd_n(bus_rd_n), .bus_we_n(bus_we_n),
    .bus_be_n(bus_be_n), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_wait(bus_wait)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_mis++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_wait(input int code);
    if (code <= 6)  return code;
    if (code <= 10) return 2 * code - 6;
    if (code == 11) return 18;
    return 24;
  endfunction

  task automatic cfg_write(input int code, input int mask, input int hold, input int junk);
    @(negedge clk);
    cfg_wr    = 1'b1;
    cfg_wdata = 11'((hold << 9) | (mask << 8) | (junk << 4) | code);
    @(negedge clk);
    cfg_wr    = 1'b0;
  endtask

  task automatic run_access(input bit rw, input int code, input int hold,
                            input int e_req, input int mask, input bit poke);
    int w        = exp_wait(code);
    int e_eff    = (mask != 0) ? 0 : e_req;
    int exp_str  = 2 * (1 + w) + 2 * e_eff;
    int exp_hold = 2 * hold + 1;
    int str = 0, hld = 0, guard = 0, bad = 0;
    bit got_done = 1'b0;
    logic [AW-1:0] a    = AW'(16'h1000 + n_acc * 37);
    logic [DW-1:0] d    = DW'(16'hA500 + n_acc * 13);
    logic [BW-1:0] be   = BW'(n_acc % 3 + 1);
    logic [DW-1:0] base = DW'(16'h2000 + n_acc * 64);
    string len_tag;
    n_acc++;
    if (e_eff > 0)                       len_tag = "R4 strobe length";
    else if (mask != 0 && e_req > 0)     len_tag = "R5 strobe length";
    else if (code >= 13)                 len_tag = "R3 strobe length";
    else                                 len_tag = "R2 strobe length";

    @(negedge clk);
    req = 1'b1; req_we = rw; req_addr = a; req_wdata = d; req_be = be;
    bus_wait = (e_req > 0); bus_rdata = base;
    @(negedge clk);
    req = 1'b0;
    while (!got_done && guard < 300) begin
      if (done) begin
        got_done = 1'b1;
        if (!bus_cs_n) bad++;
      end else if (!bus_rd_n || !bus_we_n) begin
        str++;
        if (bus_addr != a) bad++;
        if (rw  && (!bus_rd_n || bus_we_n || bus_be_n != ~be || bus_wdata != d)) bad++;
        if (!rw && (bus_rd_n || !bus_we_n || bus_be_n != '1)) bad++;
      end else if (!bus_cs_n) begin
        hld++;
        if (bus_addr != a || bus_be_n != '1) bad++;
      end
      bus_wait  = (e_req > 0) && (str <= 2 * w + 2 * e_req);
      bus_rdata = base + DW'(str) - DW'(1);
      if (poke && str == 3 && !done) begin
        req = 1'b1; req_addr = ~a;
      end else begin
        req = 1'b0;
      end
      if (!got_done) begin
        @(negedge clk);
        guard++;
      end
    end
    bus_wait = 1'b0;
    chk(got_done, "R9 done seen", got_done, 1);
    chk(str == exp_str, len_tag, str, exp_str);
    chk(hld == exp_hold, "R6 hold length", hld, exp_hold);
    chk(bad == 0, rw ? "R8 write strobes" : "R8 read strobes", bad, 0);
    if (!rw) chk(rd_data == base + DW'(exp_str) - DW'(1), "R7 read capture",
                 rd_data, base + DW'(exp_str) - DW'(1));
    @(negedge clk);
    chk(!done && bus_cs_n, "R9 done single", done, 0);
    if (poke) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(bus_cs_n, "R9 busy request ignored", bus_cs_n, 1);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_mis++;
    n_cmp++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

  initial begin
    bit seen_rsv = 1'b0;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0; req = 1'b0; req_we = 1'b0;
    req_addr = '0; req_wdata = '0; req_be = '0; bus_rdata = '0; bus_wait = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(cfg_rdata == 11'h00A, "R1 cfg reset", cfg_rdata, 11'h00A);
    chk(!cfg_err, "R1 err reset", cfg_err, 0);
    chk(bus_cs_n && bus_rd_n && bus_we_n, "R1 strobes idle",
        {bus_cs_n, bus_rd_n, bus_we_n}, 7);
    chk(bus_be_n == '1 && !done, "R1 be/done idle", bus_be_n, 3);
    run_access(1'b0, 10, 0, 0, 0, 1'b0);

    for (int code = 0; code < 16; code++) begin
      for (int mask = 0; mask < 2; mask++) begin
        for (int hold = 0; hold < 4; hold++) begin
          cfg_write(code, mask, hold, (code + hold) % 16);
          if (code >= 13) seen_rsv = 1'b1;
          @(negedge clk);
          // R10 reserved bits read as zero
          chk(cfg_rdata == 11'((hold << 9) | (mask << 8) | code), "R10 cfg readback",
              cfg_rdata, (hold << 9) | (mask << 8) | code);
          chk(cfg_err == seen_rsv, "R3 error flag", cfg_err, seen_rsv);
          for (int rw = 0; rw < 2; rw++) begin
            run_access(rw[0], code, hold, (hold + rw) % 3, mask,
                       code == 5 && hold == 1);
          end
        end
      end
    end

    // R4 zero-wait code with several extensions
    cfg_write(0, 0, 2, 0);
    run_access(1'b0, 0, 2, 2, 0, 1'b0);
    run_access(1'b1, 0, 2, 3, 0, 1'b0);
    // R5 masked with long device wait
    cfg_write(3, 1, 1, 0);
    run_access(1'b0, 3, 1, 3, 1, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

endmodule